// File: doc/BRIEF.md
# Signed Multiply-Accumulate Register Unit

This unit sits beside a processor's register file and holds a 42-bit signed accumulator. The accumulator is split into a 32-bit low word and a 10-bit high part. It takes four commands. Clear zeroes the accumulator. Load copies a 32-bit general-register value into one part. Store reads one part back out to a general register. Accumulate multiplies two signed halfwords from memory and adds the product into the accumulator.

For accumulate, a small sequencer fetches the two operands over a synchronous halfword read port. It walks two address pointers and hands each pointer back, advanced by two bytes, as a register write-back. When one pointer register supplies both operands, the operands come from consecutive halfwords and the pointer advances by four. Store and load also update a four-bit condition-flag set, which is visible on the ports.

Top module: `mac_unit`

## Requirements
- R1: Clear (`cmd_op`=0) sets both accumulator parts to zero.
- R2: Load (`cmd_op`=1) with `cmd_hi`=0 writes all 32 bits of `cmd_wdata` into the low word. With `cmd_hi`=1 only bits [9:0] are kept, so 0xA5A5A5A5 reads back as 0x000001A5.
- R3: Store (`cmd_op`=2) returns the low word when `cmd_hi`=0. When `cmd_hi`=1 it returns the high part sign-extended from bit 9 to 32 bits. The result appears on `st_data`, with `st_valid` high for one cycle after acceptance.
- R4: Accumulate (`cmd_op`=3) adds the signed 16x16 product to the full 42-bit accumulator. Carries move from the low word into the high part, and the sum wraps modulo 2^42.
- R5: With distinct pointers, the operand reads use `cmd_ptr_a` and then `cmd_ptr_b`. Each pointer is written back as its value plus 2.
- R6: With `cmd_same`=1, the reads use A and then A+2. Only `ptr_a_we` fires, and it writes back A+4.
- R7: Store sets Z from (value==0) and N from bit 31 of the stored value. It clears V and leaves C unchanged.
- R8: Load clears V and C and leaves Z and N unchanged.
- R9: Clear and accumulate leave all four flags at zero.
- R10: An accumulate keeps `busy` high for exactly three cycles after acceptance. The memory reads go out in the first two of those cycles, and each read's data arrives one cycle later. A command presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_op | input | 2 | 0 clear, 1 load, 2 store, 3 accumulate |
| cmd_hi | input | 1 | Selects the high part for load/store |
| cmd_wdata | input | 32 | Source register value for load |
| cmd_ptr_a | input | 32 | First operand pointer |
| cmd_ptr_b | input | 32 | Second operand pointer |
| cmd_same | input | 1 | Both operands use pointer A |
| busy | output | 1 | Accumulate in progress |
| st_valid | output | 1 | Store result valid |
| st_data | output | 32 | Store result |
| ptr_a_we | output | 1 | Write back pointer A |
| ptr_a_nxt | output | 32 | New value of pointer A |
| ptr_b_we | output | 1 | Write back pointer B |
| ptr_b_nxt | output | 32 | New value of pointer B |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the halfword |
| mem_rdata | input | 16 | Read data, one cycle after mem_re |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Several properties are checked on every cycle by the embedded assertions:
- the fixed IDLE, READ1, READ2, ACC state walk, with memory reads issued only while busy;
- the A+2 second address when one pointer serves both operands;
- a zeroed accumulator after clear, and an unchanged accumulator when the product is zero;
- V cleared after a store and Z/N held across a load;
- no store result from a command presented while busy.

Only the bench's scenarios can show the numeric results: signed products, the carry into the high part, sign extension on read, the modulo-2^42 wrap, pointer write-back values, and flag values computed from the stored data.

// File: rtl/mac_unit_pkg.sv
package mac_unit_pkg;
    localparam int DATA_W = 32;
    localparam int OPND_W = 16;
    localparam int HI_W   = 10;
    localparam int ADDR_W = 32;

    typedef enum logic [1:0] {
        OP_CLR   = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_ACC   = 2'd3
    } mac_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ1 = 2'd1,
        ST_READ2 = 2'd2,
        ST_ACC   = 2'd3
    } fetch_st_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } ccr_t;
endpackage

// File: rtl/mac_fetch.sv
module mac_fetch
    import mac_unit_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int OW    = OPND_W,
    parameter int STEP  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] ptr_a,
    input  logic [AW-1:0] ptr_b,
    input  logic          same,
    input  logic [OW-1:0] mem_rdata,
    output logic          busy,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic          commit,
    output logic [OW-1:0] opnd_a,
    output logic [OW-1:0] opnd_b,
    output logic          ptr_a_we,
    output logic [AW-1:0] ptr_a_nxt,
    output logic          ptr_b_we,
    output logic [AW-1:0] ptr_b_nxt
);
    localparam logic [AW-1:0] INC1 = AW'(STEP);
    localparam logic [AW-1:0] INC2 = AW'(2 * STEP);

    typedef struct packed {
        fetch_st_e     st;
        logic [AW-1:0] addr_a;
        logic [AW-1:0] addr_b;
        logic          same;
        logic [OW-1:0] op1;
    } fetch_state_t;

    fetch_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        mem_re    = 1'b0;
        mem_addr  = s_q.addr_a;
        commit    = 1'b0;
        ptr_a_we  = 1'b0;
        ptr_b_we  = 1'b0;
        ptr_a_nxt = s_q.addr_a + (s_q.same ? INC2 : INC1);
        ptr_b_nxt = s_q.addr_b + INC1;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st     = ST_READ1;
                    s_d.addr_a = ptr_a;
                    s_d.addr_b = ptr_b;
                    s_d.same   = same;
                end
            end
            ST_READ1: begin
                mem_re   = 1'b1;
                mem_addr = s_q.addr_a;
                s_d.st   = ST_READ2;
            end
            ST_READ2: begin
                mem_re   = 1'b1;
                mem_addr = s_q.same ? (s_q.addr_a + INC1) : s_q.addr_b;
                s_d.op1  = mem_rdata;
                s_d.st   = ST_ACC;
            end
            ST_ACC: begin
                commit   = 1'b1;
                ptr_a_we = 1'b1;
                ptr_b_we = !s_q.same;
                s_d.st   = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    assign busy   = (s_q.st != ST_IDLE);
    assign opnd_a = s_q.op1;
    assign opnd_b = mem_rdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R10
    read_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> busy);
    // R10
    walk_read1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_READ1) |=> (s_q.st == ST_READ2));
    // R10
    walk_read2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_READ2) |=> (s_q.st == ST_ACC) && !mem_re);
    // R10
    walk_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);
    // R6
    same_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_READ2 && s_q.same) |-> mem_addr == $past(mem_addr) + INC1);
    // R6
    same_ptr_single_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_a_we && s_q.same) |-> !ptr_b_we);
endmodule

// File: rtl/mac_acc.sv
module mac_acc
    import mac_unit_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int HW = HI_W,
    parameter int OW = OPND_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [DW-1:0] ld_data,
    input  logic          add_en,
    input  logic [OW-1:0] op_a,
    input  logic [OW-1:0] op_b,
    output logic [DW-1:0] rd_lo,
    output logic [DW-1:0] rd_hi
);
    localparam int AW = DW + HW;
    localparam int PW = 2 * OW;

    logic [AW-1:0]        acc_d, acc_q;
    logic signed [PW-1:0] prod;
    logic [AW-1:0]        prod_ext;

    always_comb begin
        prod     = $signed(op_a) * $signed(op_b);
        prod_ext = {{(AW - PW){prod[PW-1]}}, prod};
        acc_d    = acc_q;
        if (clr) begin
            acc_d = '0;
        end else if (ld_lo) begin
            acc_d[DW-1:0] = ld_data;
        end else if (ld_hi) begin
            acc_d[AW-1:DW] = ld_data[HW-1:0];
        end else if (add_en) begin
            acc_d = acc_q + prod_ext;
        end
    end

    assign rd_lo = acc_q[DW-1:0];
    assign rd_hi = {{(DW - HW){acc_q[AW-1]}}, acc_q[AW-1:DW]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (rd_lo == '0) && (rd_hi == '0));
    // R4
    zero_product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !clr && !ld_lo && !ld_hi && op_b == '0) |=> $stable(rd_lo) && $stable(rd_hi));
endmodule

// File: rtl/mac_flags.sv
module mac_flags
    import mac_unit_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zero_all,
    input  logic          ld,
    input  logic          st,
    input  logic [DW-1:0] st_value,
    output ccr_t          ccr
);
    ccr_t ccr_d, ccr_q;

    always_comb begin
        ccr_d = ccr_q;
        if (zero_all) begin
            ccr_d = '0;
        end else if (ld) begin
            ccr_d.v = 1'b0;
            ccr_d.c = 1'b0;
        end else if (st) begin
            ccr_d.z = (st_value == '0);
            ccr_d.n = st_value[DW-1];
            ccr_d.v = 1'b0;
        end
    end

    assign ccr = ccr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ccr_q <= '0;
        end else begin
            ccr_q <= ccr_d;
        end
    end

    // R7
    store_clears_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st |=> !ccr.v);
    // R8
    load_holds_zn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && !zero_all) |=> (ccr.z == $past(ccr.z)) && (ccr.n == $past(ccr.n)) && !ccr.c);
    // R9
    zero_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_all |=> (ccr == '0));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_unit_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int AW   = ADDR_W,
    parameter int OW   = OPND_W,
    parameter int HW   = HI_W,
    parameter int STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic          cmd_hi,
    input  logic [DW-1:0] cmd_wdata,
    input  logic [AW-1:0] cmd_ptr_a,
    input  logic [AW-1:0] cmd_ptr_b,
    input  logic          cmd_same,
    output logic          busy,
    output logic          st_valid,
    output logic [DW-1:0] st_data,
    output logic          ptr_a_we,
    output logic [AW-1:0] ptr_a_nxt,
    output logic          ptr_b_we,
    output logic [AW-1:0] ptr_b_nxt,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    input  logic [OW-1:0] mem_rdata,
    output logic          flag_z,
    output logic          flag_n,
    output logic          flag_v,
    output logic          flag_c
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } store_t;

    store_t  out_d, out_q;
    mac_op_e op;
    logic    accept, do_clr, do_ld, do_st, do_acc;
    logic    commit;
    logic [OW-1:0] opnd_a, opnd_b;
    logic [DW-1:0] rd_lo, rd_hi, st_value;
    ccr_t    ccr;

    always_comb begin
        op       = mac_op_e'(cmd_op);
        accept   = cmd_valid && !busy;
        do_clr   = accept && (op == OP_CLR);
        do_ld    = accept && (op == OP_LOAD);
        do_st    = accept && (op == OP_STORE);
        do_acc   = accept && (op == OP_ACC);
        st_value = cmd_hi ? rd_hi : rd_lo;
        out_d.vld  = do_st;
        out_d.data = do_st ? st_value : out_q.data;
    end

    mac_fetch #(.AW(AW), .OW(OW), .STEP(STEP)) i_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (do_acc),
        .ptr_a     (cmd_ptr_a),
        .ptr_b     (cmd_ptr_b),
        .same      (cmd_same),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .commit    (commit),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .ptr_a_we  (ptr_a_we),
        .ptr_a_nxt (ptr_a_nxt),
        .ptr_b_we  (ptr_b_we),
        .ptr_b_nxt (ptr_b_nxt)
    );

    mac_acc #(.DW(DW), .HW(HW), .OW(OW)) i_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (do_clr),
        .ld_lo   (do_ld && !cmd_hi),
        .ld_hi   (do_ld && cmd_hi),
        .ld_data (cmd_wdata),
        .add_en  (commit),
        .op_a    (opnd_a),
        .op_b    (opnd_b),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi)
    );

    mac_flags #(.DW(DW)) i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_all (do_clr || do_acc || commit),
        .ld       (do_ld),
        .st       (do_st),
        .st_value (st_value),
        .ccr      (ccr)
    );

    assign st_valid = out_q.vld;
    assign st_data  = out_q.data;
    assign flag_z   = ccr.z;
    assign flag_n   = ccr.n;
    assign flag_v   = ccr.v;
    assign flag_c   = ccr.c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    // R10
    busy_ignores_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> !st_valid);
    // R3
    store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> !st_valid || $past(cmd_valid));
endmodule

// File: tb/test_mac_unit.sv
module test_mac_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_hi = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_ptr_a = '0;
    logic [31:0] cmd_ptr_b = '0;
    logic        cmd_same = 1'b0;
    logic        busy, st_valid, ptr_a_we, ptr_b_we, mem_re;
    logic [31:0] st_data, ptr_a_nxt, ptr_b_nxt, mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        flag_z, flag_n, flag_v, flag_c;

    logic [15:0] mem [0:63];
    logic [31:0] addr_log [0:1];
    int          addr_cnt;
    logic [31:0] wb_a, wb_b;
    int          wb_a_cnt, wb_b_cnt;
    int          tests = 0;
    int          fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mac_unit i_mac_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_hi(cmd_hi), .cmd_wdata(cmd_wdata), .cmd_ptr_a(cmd_ptr_a),
        .cmd_ptr_b(cmd_ptr_b), .cmd_same(cmd_same), .busy(busy),
        .st_valid(st_valid), .st_data(st_data), .ptr_a_we(ptr_a_we),
        .ptr_a_nxt(ptr_a_nxt), .ptr_b_we(ptr_b_we), .ptr_b_nxt(ptr_b_nxt),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c)
    );

    always @(posedge clk) begin
        if (mem_re) begin
            mem_rdata <= mem[6'((mem_addr - BASE) >> 1)];
            if (addr_cnt < 2) addr_log[addr_cnt] <= mem_addr;
            addr_cnt <= addr_cnt + 1;
        end
        if (ptr_a_we) begin wb_a <= ptr_a_nxt; wb_a_cnt <= wb_a_cnt + 1; end
        if (ptr_b_we) begin wb_b <= ptr_b_nxt; wb_b_cnt <= wb_b_cnt + 1; end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(logic [1:0] op, logic hi, logic [31:0] wd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_hi = hi; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic store(logic hi, output logic [31:0] val);
        issue(2'd2, hi, '0);
        check("R3 st_valid", {31'b0, st_valid}, 32'd1);
        val = st_data;
    endtask

    task automatic accumulate(logic [31:0] pa, logic [31:0] pb, logic same, output int busy_cycles);
        addr_cnt = 0; wb_a_cnt = 0; wb_b_cnt = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_ptr_a = pa; cmd_ptr_b = pb; cmd_same = same;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy_cycles = 0;
        while (busy) begin busy_cycles++; @(negedge clk); end
    endtask

    task automatic t_reset_clear();
        logic [31:0] v;
        check("R1 reset busy", {31'b0, busy}, 32'd0);
        issue(2'd1, 1'b0, 32'h1234_5678);
        issue(2'd1, 1'b1, 32'h0000_0155);
        issue(2'd0, 1'b0, '0);
        check("R9 clear flags", {28'b0, flag_z, flag_n, flag_v, flag_c}, 32'd0);
        store(1'b0, v); check("R1 low zero", v, 32'h0);
        check("R7 Z set on zero", {31'b0, flag_z}, 32'd1);
        store(1'b1, v); check("R1 high zero", v, 32'h0);
    endtask

    task automatic t_load_store();
        logic [31:0] v;
        issue(2'd1, 1'b0, 32'hA5A5_A5A5);
        check("R8 load holds Z", {31'b0, flag_z}, 32'd1);
        check("R8 load clears V/C", {30'b0, flag_v, flag_c}, 32'd0);
        store(1'b0, v); check("R2 low load", v, 32'hA5A5_A5A5);
        check("R7 N from bit31", {30'b0, flag_z, flag_n}, 32'd1);
        issue(2'd1, 1'b1, 32'hA5A5_A5A5);
        check("R8 load holds N", {31'b0, flag_n}, 32'd1);
        store(1'b1, v); check("R2 high keeps 10 bits", v, 32'h0000_01A5);
        check("R7 positive flags", {29'b0, flag_z, flag_n, flag_v}, 32'd0);
    endtask

    task automatic t_acc_basic();
        logic [31:0] v;
        int bc;
        mem[0] = 16'd2; mem[1] = 16'd2; mem[8] = 16'hFFFE;
        issue(2'd0, 1'b0, '0);
        accumulate(BASE, BASE + 2, 1'b0, bc);
        check("R10 busy cycles", bc, 32'd3);
        check("R5 first addr", addr_log[0], BASE);
        check("R5 second addr", addr_log[1], BASE + 2);
        check("R5 wb a", wb_a, BASE + 2);
        check("R5 wb b", wb_b, BASE + 4);
        check("R9 acc flags", {28'b0, flag_z, flag_n, flag_v, flag_c}, 32'd0);
        store(1'b0, v); check("R4 2x2", v, 32'd4);
        issue(2'd0, 1'b0, '0);
        accumulate(BASE + 16, BASE + 2, 1'b0, bc);
        store(1'b0, v); check("R4 -2x2 low", v, 32'hFFFF_FFFC);
        store(1'b1, v); check("R3 high sign-extended", v, 32'hFFFF_FFFF);
        check("R7 N set", {30'b0, flag_z, flag_n}, 32'd1);
    endtask

    task automatic t_same_ptr();
        logic [31:0] v;
        int bc;
        mem[2] = 16'd2; mem[3] = 16'd4;
        issue(2'd0, 1'b0, '0);
        accumulate(BASE + 4, 32'hDEAD_BEEF, 1'b1, bc);
        check("R6 addr A", addr_log[0], BASE + 4);
        check("R6 addr A+2", addr_log[1], BASE + 6);
        check("R6 wb A+4", wb_a, BASE + 8);
        check("R6 no wb b", wb_b_cnt, 32'd0);
        store(1'b0, v); check("R6 2x4", v, 32'd8);
    endtask

    task automatic t_array_carry();
        logic [31:0] v;
        int bc;
        for (int i = 16; i < 32; i++) mem[i] = 16'h7FFF;
        issue(2'd0, 1'b0, '0);
        for (int k = 0; k < 8; k++) accumulate(BASE + 32 + 32'(4 * k), '0, 1'b1, bc);
        check("R6 final ptr", wb_a, BASE + 64);
        store(1'b0, v); check("R4 carry low", v, 32'hFFF8_0008);
        store(1'b1, v); check("R4 carry high", v, 32'd1);
    endtask

    task automatic t_wrap_busy();
        logic [31:0] v;
        int bc;
        mem[4] = 16'd1; mem[5] = 16'd1;
        issue(2'd1, 1'b1, 32'h0000_01FF);
        issue(2'd1, 1'b0, 32'hFFFF_FFFF);
        addr_cnt = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_ptr_a = BASE + 8; cmd_ptr_b = BASE + 10; cmd_same = 1'b0;
        @(negedge clk);
        cmd_op = 2'd0;
        @(negedge clk);
        cmd_op = 2'd2;
        @(negedge clk);
        check("R10 ignored store", {31'b0, st_valid}, 32'd0);
        cmd_valid = 1'b0;
        @(negedge clk);
        check("R10 done", {31'b0, busy}, 32'd0);
        store(1'b0, v); check("R4 wrap low", v, 32'h0);
        store(1'b1, v); check("R4 wrap high", v, 32'hFFFF_FE00);
        check("R10 clear ignored, N", {31'b0, flag_n}, 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        addr_cnt = 0; wb_a = '0; wb_b = '0; wb_a_cnt = 0; wb_b_cnt = 0;
        addr_log[0] = '0; addr_log[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_clear();
        t_load_store();
        t_acc_basic();
        t_same_ptr();
        t_array_carry();
        t_wrap_busy();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule